// File: doc/BRIEF.md
# Lockable Configuration Shadow Store with Parity Monitor

The block keeps a working copy of a small non-volatile configuration area: ten bytes at addresses 0x06 to 0x0F. After every reset it fills that copy from a streaming load port, one byte per accepted transfer, lowest address first. Once the fill is done it takes byte-program requests from a strobe-driven program port. A write lock guards those requests. The lock's value is sampled only as the fill completes, so programming the lock bit has no effect until the next reset. One bit, the data-disable flag, stays writable while the area is locked.

While locked, the block watches even parity over every protected bit except the lock bit. A mismatch sets a sticky fault that lasts until the next reset. The full shadow contents are driven out continuously for the rest of the device.

Sensor samples pass through a one-entry valid/ready stage. Under a fault, the data field reaches the output as zero and the status flag is set. The input stage offers `sin_ready` whenever its single register is empty or is being emptied in the same cycle. The output holds `sout_valid` and its sample until `sout_ready` is seen.

Top module: `cfg_shadow_store`

## Requirements
- R1: While `rst_n` is low, `load_done`, `lock_active`, `par_fault`, `pg_reject`, `sout_valid`, `sout_status` and all of `cfg_bytes` are 0.
- R2: After reset, `ld_ready` is 1 until ten `ld_valid` transfers have been taken. The byte for address 0x06+i appears at `cfg_bytes[8i+7:8i]` on the cycle after its transfer. On the cycle after the tenth transfer, `load_done` is 1 and `ld_ready` is 0.
- R3: With `load_done` 1 and `lock_active` 0, a strobe to an address from 0x06 to 0x0F replaces that whole byte, visible on the next cycle. This includes setting the lock bit (bit 7 of 0x07), and later requests are still accepted until reset.
- R4: `lock_active` equals bit 7 of the byte loaded into 0x07, from the cycle `load_done` rises until the next reset.
- R5: With `lock_active` 1, a strobe to 0x07 is accepted but changes only bit 4 of that byte, the data-disable flag. Strobes to every other address are refused.
- R6: A refused request leaves `cfg_bytes` unchanged and raises `pg_reject` for exactly the cycle after the strobe. A request is refused when the address is outside 0x06–0x0F, when `load_done` is 0, or under R5. Accepted requests never raise `pg_reject`.
- R7: With `lock_active` 1, `par_fault` rises one cycle after the count of 1s over all 80 shadow bits, excluding bit 7 of 0x07, becomes odd. With `lock_active` 0, `par_fault` stays 0.
- R8: Once set, `par_fault` stays 1 until reset, even if the parity becomes even again. A reset followed by a reload with even parity leaves it 0.
- R9: While `par_fault` is 1, `sout_data` is 0 and `sout_status` is 1. Otherwise `sout_data` is the accepted sample, unchanged, and `sout_status` is 0.
- R10: `sin_ready` equals `!sout_valid || sout_ready`. Samples leave in arrival order. With `sout_valid` 1 and `sout_ready` 0, `sout_valid` stays 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a new fill |
| ld_valid | input | 1 | Fill byte offered |
| ld_ready | output | 1 | Fill in progress, byte will be taken |
| ld_data | input | 8 | Fill byte, lowest address first |
| load_done | output | 1 | All ten bytes filled |
| pg_strobe | input | 1 | Program request |
| pg_addr | input | 4 | Program address |
| pg_data | input | 8 | Program data |
| pg_reject | output | 1 | One-cycle pulse for a refused request |
| cfg_bytes | output | 80 | Shadow contents, byte i at bits 8i+7:8i |
| lock_active | output | 1 | Lock state sampled at fill end |
| par_fault | output | 1 | Sticky parity fault |
| sin_valid | input | 1 | Sensor sample offered |
| sin_ready | output | 1 | Sensor sample accepted this cycle |
| sin_data | input | 12 | Sensor sample |
| sout_valid | output | 1 | Response sample available |
| sout_ready | input | 1 | Consumer takes the response |
| sout_data | output | 12 | Response data, zero under fault |
| sout_status | output | 1 | Fault status flag of the response |

## Verification
The properties assume `pg_strobe` is only a request and carries no other timing duty. They also assume the consumer may stall `sout_ready` for any length of time. The stall assumption matters for the hold property. The bench drives every input on the falling edge and holds `pg_strobe` for one cycle per request. It drives `ld_valid` only while a fill is wanted, with random idle gaps. During stream phases it keeps the program port quiet, so every change to the fault during a phase comes from a known program step.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

  localparam int unsigned CFG_W    = 8;
  localparam int unsigned LOCK_POS = 7;
  localparam int unsigned DDIS_POS = 4;

  typedef enum logic {
    LDR_FILL = 1'b0,
    LDR_RUN  = 1'b1
  } ldr_state_e;

  // bits a program request may change in one byte
  function automatic logic [CFG_W-1:0] prog_mask(input logic locked, input logic is_lock_byte);
    logic [CFG_W-1:0] m;
    if (!locked)           m = '1;
    else if (is_lock_byte) m = CFG_W'(1) << DDIS_POS;
    else                   m = '0;
    return m;
  endfunction

endpackage

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_store_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 10,
  localparam int unsigned IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_last,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  ldr_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  assign ld_ready = (state_q == LDR_FILL);
  assign wr_en    = ld_valid && ld_ready;
  assign wr_idx   = idx_q;
  assign wr_last  = wr_en && (idx_q == LAST_IDX);
  assign done     = (state_q == LDR_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LDR_FILL;
      idx_q   <= '0;
    end else if (wr_en) begin
      if (wr_last) begin
        state_q <= LDR_RUN;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_store_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 10,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BASE_ADDR = 6,
  parameter int unsigned LOCK_IDX  = 1,
  localparam int unsigned IDX_W  = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int unsigned FLAT_W = NUM_BYTES * CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic              fill_last,
  input  logic [CFG_W-1:0]  fill_byte,
  input  logic              run,
  input  logic              pg_strobe,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [CFG_W-1:0]  pg_data,
  output logic [FLAT_W-1:0] cfg_flat,
  output logic              lock_q,
  output logic              pg_reject
);

  localparam int unsigned LAST_ADDR = BASE_ADDR + NUM_BYTES - 1;

  logic [CFG_W-1:0] mem [NUM_BYTES];
  logic             pg_in_range;
  logic [IDX_W-1:0] pg_idx;
  logic             pg_is_lock_byte;
  logic [CFG_W-1:0] pg_mask;
  logic             pg_allow;
  logic             lock_src;

  assign pg_in_range     = (32'(pg_addr) >= BASE_ADDR) && (32'(pg_addr) <= LAST_ADDR);
  assign pg_idx          = IDX_W'(32'(pg_addr) - BASE_ADDR);
  assign pg_is_lock_byte = (pg_idx == IDX_W'(LOCK_IDX));
  assign pg_mask         = prog_mask(lock_q, pg_is_lock_byte);
  assign pg_allow        = run && pg_in_range && (pg_mask != '0);

  // lock bit as it stands once the last fill byte lands
  assign lock_src = (fill_idx == IDX_W'(LOCK_IDX)) ? fill_byte[LOCK_POS] : mem[LOCK_IDX][LOCK_POS];

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (fill_we && (fill_idx == IDX_W'(i))) begin
        mem[i] <= fill_byte;
      end else if (pg_strobe && pg_allow && (pg_idx == IDX_W'(i))) begin
        mem[i] <= (mem[i] & ~pg_mask) | (pg_data & pg_mask);
      end
    end
    assign cfg_flat[i*CFG_W +: CFG_W] = mem[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      pg_reject <= 1'b0;
    end else begin
      if (fill_last) begin
        lock_q <= lock_src;
      end
      pg_reject <= pg_strobe && !pg_allow;
    end
  end

endmodule

// File: rtl/cfg_parity_mon.sv
module cfg_parity_mon #(
  parameter int unsigned NBITS    = 80,
  parameter int unsigned EXCL_POS = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [NBITS-1:0] bits,
  output logic             fault
);

  localparam logic [NBITS-1:0] KEEP = ~(NBITS'(1) << EXCL_POS);

  logic odd;
  assign odd = ^(bits & KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault <= 1'b0;
    end else if (enable && odd) begin
      fault <= 1'b1;
    end
  end

endmodule

// File: rtl/resp_stage.sv
module resp_stage #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_status
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready   = !full_q || out_ready;
  assign out_valid  = full_q;
  assign out_data   = blank ? '0 : data_q;
  assign out_status = blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_shadow_store.sv
module cfg_shadow_store
  import cfg_store_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 10,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BASE_ADDR = 6,
  parameter int unsigned LOCK_IDX  = 1,
  parameter int unsigned DATA_W    = 12,
  localparam int unsigned IDX_W  = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int unsigned FLAT_W = NUM_BYTES * CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [CFG_W-1:0]  ld_data,
  output logic              load_done,
  input  logic              pg_strobe,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [CFG_W-1:0]  pg_data,
  output logic              pg_reject,
  output logic [FLAT_W-1:0] cfg_bytes,
  output logic              lock_active,
  output logic              par_fault,
  input  logic              sin_valid,
  output logic              sin_ready,
  input  logic [DATA_W-1:0] sin_data,
  output logic              sout_valid,
  input  logic              sout_ready,
  output logic [DATA_W-1:0] sout_data,
  output logic              sout_status
);

  logic             fill_we;
  logic [IDX_W-1:0] fill_idx;
  logic             fill_last;

  cfg_loader #(.NUM_BYTES(NUM_BYTES)) u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_ready (ld_ready),
    .wr_en    (fill_we),
    .wr_idx   (fill_idx),
    .wr_last  (fill_last),
    .done     (load_done)
  );

  cfg_regfile #(
    .NUM_BYTES (NUM_BYTES),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .LOCK_IDX  (LOCK_IDX)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_we   (fill_we),
    .fill_idx  (fill_idx),
    .fill_last (fill_last),
    .fill_byte (ld_data),
    .run       (load_done),
    .pg_strobe (pg_strobe),
    .pg_addr   (pg_addr),
    .pg_data   (pg_data),
    .cfg_flat  (cfg_bytes),
    .lock_q    (lock_active),
    .pg_reject (pg_reject)
  );

  cfg_parity_mon #(
    .NBITS    (FLAT_W),
    .EXCL_POS (LOCK_IDX * CFG_W + LOCK_POS)
  ) u_par (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (load_done && lock_active),
    .bits   (cfg_bytes),
    .fault  (par_fault)
  );

  resp_stage #(.DATA_W(DATA_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank      (par_fault),
    .in_valid   (sin_valid),
    .in_ready   (sin_ready),
    .in_data    (sin_data),
    .out_valid  (sout_valid),
    .out_ready  (sout_ready),
    .out_data   (sout_data),
    .out_status (sout_status)
  );

endmodule

// File: rtl/cfg_shadow_store_sva.sv
module cfg_shadow_store_sva #(
  parameter int unsigned NUM_BYTES = 10,
  parameter int unsigned LOCK_IDX  = 1,
  parameter int unsigned DATA_W    = 12,
  localparam int unsigned FLAT_W = NUM_BYTES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_ready,
  input logic              load_done,
  input logic              pg_strobe,
  input logic              pg_reject,
  input logic [FLAT_W-1:0] cfg_bytes,
  input logic              lock_active,
  input logic              par_fault,
  input logic              sout_valid,
  input logic              sout_ready,
  input logic [DATA_W-1:0] sout_data,
  input logic              sout_status
);

  localparam logic [FLAT_W-1:0] FROZEN = ~(FLAT_W'(1) << (LOCK_IDX * 8 + 4));

  AST_FILL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !ld_ready); // R2

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && $past(load_done)) |-> $stable(lock_active)); // R4

  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && lock_active) |=> ((cfg_bytes & FROZEN) == ($past(cfg_bytes) & FROZEN))); // R5

  AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pg_reject |-> $past(pg_strobe)); // R6

  AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_active |-> !par_fault); // R7

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    par_fault |=> par_fault); // R8

  AST_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    (par_fault && sout_valid) |-> ((sout_data == '0) && sout_status)); // R9

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sout_valid && !sout_ready) |=> sout_valid); // R10

endmodule

bind cfg_shadow_store cfg_shadow_store_sva #(
  .NUM_BYTES (NUM_BYTES),
  .LOCK_IDX  (LOCK_IDX),
  .DATA_W    (DATA_W)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .ld_ready    (ld_ready),
  .load_done   (load_done),
  .pg_strobe   (pg_strobe),
  .pg_reject   (pg_reject),
  .cfg_bytes   (cfg_bytes),
  .lock_active (lock_active),
  .par_fault   (par_fault),
  .sout_valid  (sout_valid),
  .sout_ready  (sout_ready),
  .sout_data   (sout_data),
  .sout_status (sout_status)
);

// File: tb/sim_cfg_shadow_store.sv
`timescale 1ns/1ps
module sim_cfg_shadow_store;

  localparam int NB = 10;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [7:0]    ld_data = '0;
  logic          load_done;
  logic          pg_strobe = 1'b0;
  logic [3:0]    pg_addr = '0;
  logic [7:0]    pg_data = '0;
  logic          pg_reject;
  logic [NB*8-1:0] cfg_bytes;
  logic          lock_active;
  logic          par_fault;
  logic          sin_valid = 1'b0;
  logic          sin_ready;
  logic [DW-1:0] sin_data = '0;
  logic          sout_valid;
  logic          sout_ready = 1'b1;
  logic [DW-1:0] sout_data;
  logic          sout_status;

  always #2 clk = ~clk;

  cfg_shadow_store u0 (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0]    m [NB];
  logic          m_lock = 1'b0;
  logic          m_fault = 1'b0;
  logic [DW-1:0] q [$];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NB*8-1:0] packed_model();
    logic [NB*8-1:0] f;
    for (int i = 0; i < NB; i++) f[i*8 +: 8] = m[i];
    return f;
  endfunction

  function automatic bit model_odd();
    bit p = 1'b0;
    for (int i = 0; i < NB; i++) p ^= ^m[i];
    return p ^ m[1][7];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ld_valid = 1'b0; pg_strobe = 1'b0; sin_valid = 1'b0; sout_ready = 1'b1;
    #1;
    chk(load_done == 0 && lock_active == 0 && par_fault == 0 && pg_reject == 0 &&
        sout_valid == 0 && sout_status == 0 && cfg_bytes == '0, "R1 reset state",
        {load_done, lock_active, par_fault, pg_reject, sout_valid, sout_status}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NB; i++) m[i] = '0;
    m_lock = 1'b0; m_fault = 1'b0;
  endtask

  // img: bytes to load; lock: lock bit; even: force even protected parity
  task automatic do_load(input bit lock, input bit even);
    logic [7:0] img [NB];
    bit p;
    for (int i = 0; i < NB; i++) img[i] = 8'($urandom);
    img[1][7] = lock;
    p = 1'b0;
    for (int i = 0; i < NB; i++) p ^= ^img[i];
    p ^= img[1][7];
    if (p == even) img[1][6] = ~img[1][6];
    for (int i = 0; i < NB; i++) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); ld_valid = 1'b0;
      end
      @(negedge clk);
      chk(ld_ready == 1 && load_done == 0, "R2 fill ready", {ld_ready, load_done}, 2'b10);
      ld_valid = 1'b1; ld_data = img[i];
      @(posedge clk); #1;
      m[i] = img[i];
      if (i > 0) chk(cfg_bytes[i*8 +: 8] == img[i], "R2 byte placed", cfg_bytes[i*8 +: 8], img[i]);
    end
    @(negedge clk); ld_valid = 1'b0;
    chk(load_done == 1 && ld_ready == 0, "R2 fill done", {load_done, ld_ready}, 2'b10);
    chk(cfg_bytes == packed_model(), "R2 image", cfg_bytes, packed_model());
    m_lock = lock;
    chk(lock_active == m_lock, "R4 lock sampled", lock_active, m_lock);
    @(posedge clk); #1;
    if (m_lock && model_odd()) m_fault = 1'b1;
    chk(par_fault == m_fault, "R7 fault after fill", par_fault, m_fault);
  endtask

  task automatic do_prog(input logic [3:0] a, input logic [7:0] d);
    bit inr = (a >= 4'd6);
    int idx = int'(a) - 6;
    bit refused = !load_done || !inr || (m_lock && idx != 1);
    @(negedge clk);
    pg_strobe = 1'b1; pg_addr = a; pg_data = d;
    @(posedge clk); #1;
    if (!refused) begin
      if (m_lock) m[idx][4] = d[4];
      else m[idx] = d;
    end
    chk(pg_reject == refused, "R6 reject pulse", pg_reject, refused);
    chk(cfg_bytes == packed_model(), m_lock ? "R5 locked contents" : "R3 contents",
        cfg_bytes, packed_model());
    @(negedge clk); pg_strobe = 1'b0;
    @(posedge clk); #1;
    chk(pg_reject == 0, "R6 single cycle", pg_reject, 0);
    if (m_lock && load_done && model_odd()) m_fault = 1'b1;
    chk(par_fault == m_fault, "R7 R8 fault state", par_fault, m_fault);
    chk(lock_active == m_lock, "R4 lock held", lock_active, m_lock);
  endtask

  task automatic stream_step(input bit v, input bit r);
    logic [DW-1:0] e;
    @(negedge clk);
    sin_valid = v; sin_data = DW'($urandom); sout_ready = r;
    #1;
    chk(sin_ready == (!sout_valid || sout_ready), "R10 ready rule", sin_ready, !sout_valid || sout_ready);
    if (sout_valid && sout_ready) begin
      e = q.pop_front();
      if (m_fault) e = '0;
      chk(sout_data == e && sout_status == m_fault, "R9 response", {sout_status, sout_data}, {m_fault, e});
    end
    if (sin_valid && sin_ready) q.push_back(sin_data);
  endtask

  task automatic do_stream(input int n);
    for (int k = 0; k < n; k++) stream_step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0);
    for (int k = 0; k < 3; k++) stream_step(1'b0, 1'b1);
    chk(q.size() == 0, "R10 order drained", q.size(), 0);
    @(negedge clk); sin_valid = 1'b0; sout_ready = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd5117));
    do_reset();
    do_prog(4'h6, 8'hA5);                 // R6 held off before fill
    do_load(1'b0, 1'b0);                  // unlocked, odd parity: R7 quiet
    do_stream(200);                       // R9 R10 pass-through
    for (int k = 0; k < 40; k++) do_prog(4'($urandom), 8'($urandom)); // R3 R6
    do_prog(4'h7, {1'b1, 7'($urandom)});  // R3 lock written, not yet active
    do_prog(4'hC, 8'h3C);                 // R3 still accepted
    do_prog(4'h2, 8'hFF);                 // R6 out of range
    do_stream(50);

    do_reset();
    do_load(1'b1, 1'b1);                  // locked, even: R4 R7
    do_prog(4'hA, 8'h55);                 // R5 refused
    do_prog(4'h7, {~m[1][7:5], m[1][4], ~m[1][3:0]}); // R5 only DDIS, unchanged
    do_stream(100);
    do_prog(4'h7, {m[1][7:5], ~m[1][4], m[1][3:0]});  // R7 DDIS flip -> fault
    do_stream(100);                       // R9 blanked
    do_prog(4'h7, {m[1][7:5], ~m[1][4], m[1][3:0]});  // R8 sticky
    for (int k = 0; k < 20; k++) do_prog(4'($urandom), 8'($urandom));
    do_stream(60);

    do_reset();
    do_load(1'b1, 1'b0);                  // locked, odd image: R7
    do_stream(80);                        // R9
    do_reset();
    do_load(1'b1, 1'b1);                  // R8 cleared by reload
    do_stream(80);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule